// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical memory address. It keeps four segment registers (code, primary data, extra data, stack) plus an instruction offset register. The base is the chosen segment register shifted up by four bits, which places every segment on a 16-byte boundary. The offset is added to that base, and the result wraps inside the 1 MB space.

A requester presents an access kind, an optional segment override and an offset. One cycle later the block returns the physical address with a valid strobe. Each access kind has its own default segment. Instruction fetches always pair the code segment with the internal instruction offset. Stack accesses always use the stack segment. General data accesses default to the primary data segment, and an override can select any of the four.

Segment registers and the instruction offset register are loaded through simple write ports. Reset points the code segment and instruction offset at the boot location near the top of memory.

Top module: `seg_addr_unit`

## Requirements
- R1: A request accepted on a clock edge produces `addr_out` = (segment × 16 + offset) on the following cycle, with the segment and offset chosen as R4–R6 describe.
- R2: `addr_valid` is high in exactly the cycle after each cycle with `req_valid` high. In cycles without a request, `addr_valid` is low and `addr_out` keeps its last value.
- R3: A sum at or above 2^20 wraps modulo 2^20; the carry out of bit 19 is dropped (segment 0xFFFF with offset 0xFFFF gives 0x0FFEF).
- R4: Access kind 0 (fetch) always uses the code segment and the instruction offset register. `req_offset` and the override inputs are ignored.
- R5: Access kind 1 (stack) always uses the stack segment. The override inputs are ignored.
- R6: Access kinds 2 and 3 (data) use the primary data segment unless `req_ovr_en` is high. When it is high, `req_ovr_sel` picks the segment: 0 code, 1 primary data, 2 extra, 3 stack.
- R7: A segment write (`seg_wr_sel` coded as in R6) takes effect from the next cycle. A request in the same cycle as the write still sees the old value.
- R8: After reset the code segment is 0xFFFF and the instruction offset is 0x0000, so the first fetch yields 0xFFFF0. The other segments are 0, `addr_valid` is 0 and `addr_out` is 0.
- R9: A write to the instruction offset register takes effect from the next cycle, with the same timing as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | Segment value to write |
| ip_wr_en | input | 1 | Instruction offset write strobe |
| ip_wr_data | input | 16 | Instruction offset value |
| req_valid | input | 1 | Address request strobe |
| req_type | input | 2 | Access kind: 0 fetch, 1 stack, 2/3 data |
| req_ovr_en | input | 1 | Segment override enable |
| req_ovr_sel | input | 2 | Override segment |
| req_offset | input | 16 | Offset for stack and data accesses |
| addr_valid | output | 1 | Physical address valid |
| addr_out | output | 20 | Physical address |

## Verification
A segment or instruction offset write and an address request can land in the same cycle. The request must then be formed from the value held before the write. The bench provokes this by driving a write and a request to the same register on one edge. It expects the old-value address on the next cycle and the new-value address on a following request. The bench also sweeps every access kind, override setting and override target over several segment and offset patterns, including sums that carry past bit 19, and checks each result against arithmetic done in the bench.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

   localparam int NUM_SEG = 4;
   localparam int SEL_W   = $clog2(NUM_SEG);

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_STACK = 2'd1,
      ACC_DATA  = 2'd2,
      ACC_DATA2 = 2'd3
   } acc_kind_e;

   typedef enum logic [SEL_W-1:0] {
      SEG_CODE  = 2'd0,
      SEG_DATA  = 2'd1,
      SEG_EXTRA = 2'd2,
      SEG_STACK = 2'd3
   } seg_id_e;

endpackage

// File: rtl/seg_bank.sv
module seg_bank
   import seg_addr_pkg::*;
#(
   parameter int          SEG_W    = 16,
   parameter logic [15:0] RESET_CS = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [SEG_W-1:0] wr_data,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [SEG_W-1:0] rd_data
);

   logic [SEG_W-1:0] seg_q [NUM_SEG];

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      localparam logic [SEG_W-1:0] INIT_V =
         (g == int'(SEG_CODE)) ? SEG_W'(RESET_CS) : '0;

      always_ff @(posedge clk) begin
         if (!rst_n)
            seg_q[g] <= INIT_V;
         else if (wr_en && (wr_sel == SEL_W'(g)))
            seg_q[g] <= wr_data;
      end

      AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (wr_sel == SEL_W'(g))) |=> $stable(seg_q[g])); // R7

      AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (wr_sel == SEL_W'(g))) |=> (seg_q[g] == $past(wr_data))); // R7
   end

   assign rd_data = seg_q[rd_sel];

endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_addr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_type,
   input  logic             ovr_en,
   input  logic [SEL_W-1:0] ovr_sel,
   output logic [SEL_W-1:0] seg_sel,
   output logic             use_ip
);

   acc_kind_e kind;
   assign kind = acc_kind_e'(req_type);

   always_comb begin
      seg_sel = SEG_DATA;
      use_ip  = 1'b0;
      unique case (kind)
         ACC_FETCH: begin
            seg_sel = SEG_CODE;
            use_ip  = 1'b1;
         end
         ACC_STACK: seg_sel = SEG_STACK;
         ACC_DATA, ACC_DATA2: seg_sel = ovr_en ? ovr_sel : SEG_DATA;
         default: seg_sel = SEG_DATA;
      endcase
   end

   AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_type == 2'd0) |-> (seg_sel == SEG_CODE && use_ip)); // R4

   AST_STACK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_type == 2'd1) |-> (seg_sel == SEG_STACK && !use_ip)); // R5

   AST_DATA_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_type[1] && !ovr_en) |-> (seg_sel == SEG_DATA)); // R6

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int SPLIT  = 1,
   localparam int ADDR_W = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] sum
);

   if (SHIFT < 1 || OFF_W <= SHIFT)
      $error("seg_adder: SHIFT must be at least 1 and below OFF_W");
   if (OFF_W >= ADDR_W || (OFF_W - SHIFT) >= SEG_W)
      $error("seg_adder: offset too wide for the address");

   if (SPLIT != 0) begin : g_split
      localparam int HI_OFF_W = OFF_W - SHIFT;
      logic [SEG_W-1:0] hi;
      assign hi  = seg + {{(SEG_W-HI_OFF_W){1'b0}}, off[OFF_W-1:SHIFT]};
      assign sum = {hi, off[SHIFT-1:0]};
   end else begin : g_flat
      logic [ADDR_W-1:0] base;
      assign base = {seg, {SHIFT{1'b0}}};
      assign sum  = base + {{(ADDR_W-OFF_W){1'b0}}, off};
   end

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
   import seg_addr_pkg::*;
#(
   parameter int          SEG_W    = 16,
   parameter int          OFF_W    = 16,
   parameter int          SHIFT    = 4,
   parameter int          SPLIT    = 1,
   parameter logic [15:0] RESET_CS = 16'hFFFF,
   parameter logic [15:0] RESET_IP = 16'h0000,
   localparam int         ADDR_W   = SEG_W + SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_wr_en,
   input  logic [1:0]        seg_wr_sel,
   input  logic [SEG_W-1:0]  seg_wr_data,
   input  logic              ip_wr_en,
   input  logic [OFF_W-1:0]  ip_wr_data,
   input  logic              req_valid,
   input  logic [1:0]        req_type,
   input  logic              req_ovr_en,
   input  logic [1:0]        req_ovr_sel,
   input  logic [OFF_W-1:0]  req_offset,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] addr_out
);

   if (SEL_W != 2)
      $error("seg_addr_unit: select ports assume four segments");

   logic [SEL_W-1:0]  seg_sel;
   logic              use_ip;
   logic [SEG_W-1:0]  seg_val;
   logic [OFF_W-1:0]  ip_q;
   logic [OFF_W-1:0]  eff_off;
   logic [ADDR_W-1:0] sum;
   logic              valid_q;
   logic [ADDR_W-1:0] addr_q;

   seg_bank #(.SEG_W(SEG_W), .RESET_CS(RESET_CS)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (seg_wr_en),
      .wr_sel  (seg_wr_sel),
      .wr_data (seg_wr_data),
      .rd_sel  (seg_sel),
      .rd_data (seg_val)
   );

   seg_select i_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_type  (req_type),
      .ovr_en    (req_ovr_en),
      .ovr_sel   (req_ovr_sel),
      .seg_sel   (seg_sel),
      .use_ip    (use_ip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         ip_q <= OFF_W'(RESET_IP);
      else if (ip_wr_en)
         ip_q <= ip_wr_data;
   end

   assign eff_off = use_ip ? ip_q : req_offset;

   seg_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .SPLIT(SPLIT)) i_add (
      .seg (seg_val),
      .off (eff_off),
      .sum (sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
      end else begin
         valid_q <= req_valid;
         if (req_valid)
            addr_q <= sum;
      end
   end

   assign addr_valid = valid_q;
   assign addr_out   = addr_q;

   AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> addr_valid); // R2

   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !addr_valid); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(addr_out)); // R2

   AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (addr_out[SHIFT-1:0] == $past(eff_off[SHIFT-1:0]))); // R1

   AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ip_wr_en |=> $stable(ip_q)); // R9

endmodule

// File: tb/test_seg_addr_unit.sv
module test_seg_addr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_wr_en = 1'b0;
   logic [1:0]  seg_wr_sel = '0;
   logic [15:0] seg_wr_data = '0;
   logic        ip_wr_en = 1'b0;
   logic [15:0] ip_wr_data = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_type = '0;
   logic        req_ovr_en = 1'b0;
   logic [1:0]  req_ovr_sel = '0;
   logic [15:0] req_offset = '0;
   logic        addr_valid;
   logic [19:0] addr_out;

   int total = 0;
   int bad   = 0;
   int m_seg [4];
   int m_ip;

   always #2 clk = ~clk;

   seg_addr_unit i_seg_addr_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .seg_wr_en   (seg_wr_en),
      .seg_wr_sel  (seg_wr_sel),
      .seg_wr_data (seg_wr_data),
      .ip_wr_en    (ip_wr_en),
      .ip_wr_data  (ip_wr_data),
      .req_valid   (req_valid),
      .req_type    (req_type),
      .req_ovr_en  (req_ovr_en),
      .req_ovr_sel (req_ovr_sel),
      .req_offset  (req_offset),
      .addr_valid  (addr_valid),
      .addr_out    (addr_out)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
      end
   endtask

   function automatic int phys(input int seg, input int off);
      return ((seg << 4) + off) & 32'hFFFFF;
   endfunction

   function automatic int expect_addr(input int t, input int oe, input int os, input int off);
      if (t == 0) return phys(m_seg[0], m_ip);
      if (t == 1) return phys(m_seg[3], off);
      if (oe != 0) return phys(m_seg[os], off);
      return phys(m_seg[1], off);
   endfunction

   task automatic seg_write(input int sel, input int val);
      seg_wr_en = 1'b1; seg_wr_sel = 2'(sel); seg_wr_data = 16'(val);
      @(negedge clk);
      seg_wr_en = 1'b0;
      m_seg[sel] = val;
   endtask

   task automatic request(input string tag, input int t, input int oe, input int os, input int off);
      int e;
      e = expect_addr(t, oe, os, off);
      req_valid = 1'b1; req_type = 2'(t); req_ovr_en = oe[0];
      req_ovr_sel = 2'(os); req_offset = 16'(off);
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " valid"}, int'(addr_valid), 1);
      check(tag, int'(addr_out), e);
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int offs [6] = '{32'h0000, 32'h0102, 32'h000F, 32'h8001, 32'hFFF0, 32'hFFFF};
      int segv [5] = '{32'h0000, 32'h135F, 32'h8000, 32'hF00F, 32'hFFFF};
      int hold;
      m_seg[0] = 32'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0; m_ip = 0;
      repeat (3) @(negedge clk);
      check("R8 reset valid", int'(addr_valid), 0);
      check("R8 reset addr", int'(addr_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      request("R8 boot fetch", 0, 0, 0, 32'h1234);
      check("R8 boot value", int'(addr_out), 32'hFFFF0);

      seg_write(1, 32'h135F);
      request("R1 example", 2, 0, 0, 32'h0102);
      check("R1 example value", int'(addr_out), 32'h136F2);

      // R3 wrap past 1 MB
      seg_write(2, 32'hFFFF);
      request("R3 wrap", 2, 1, 2, 32'hFFFF);
      check("R3 wrap value", int'(addr_out), 32'h0FFEF);

      // R2 idle: valid drops, address holds
      hold = int'(addr_out);
      @(negedge clk);
      check("R2 idle valid", int'(addr_valid), 0);
      check("R2 idle hold", int'(addr_out), hold);

      // sweep: each pattern writes all segments, then every kind and override
      foreach (segv[k]) begin
         for (int s = 0; s < 4; s++) seg_write(s, (segv[k] + s * 32'h1111) & 32'hFFFF);
         ip_wr_en = 1'b1; ip_wr_data = 16'(segv[k] ^ 32'h0A5A);
         @(negedge clk);
         ip_wr_en = 1'b0; m_ip = (segv[k] ^ 32'h0A5A) & 32'hFFFF;
         foreach (offs[o]) begin
            for (int t = 0; t < 4; t++) begin
               for (int oe = 0; oe < 2; oe++) begin
                  for (int os = 0; os < 4; os++) begin
                     if (t == 0) request("R4 fetch", t, oe, os, offs[o]);
                     else if (t == 1) request("R5 stack", t, oe, os, offs[o]);
                     else request("R6 data", t, oe, os, offs[o]);
                  end
               end
            end
         end
      end

      // R7 write and request in the same cycle
      seg_write(1, 32'h2000);
      seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h3000;
      req_valid = 1'b1; req_type = 2'd2; req_ovr_en = 1'b0; req_offset = 16'h0010;
      @(negedge clk);
      seg_wr_en = 1'b0; req_valid = 1'b0;
      check("R7 old segment", int'(addr_out), 32'h20010);
      m_seg[1] = 32'h3000;
      request("R7 new segment", 2, 0, 0, 32'h0010);
      check("R7 new value", int'(addr_out), 32'h30010);

      // R9 instruction offset written with a fetch in the same cycle
      ip_wr_en = 1'b1; ip_wr_data = 16'h0040;
      req_valid = 1'b1; req_type = 2'd0; req_offset = 16'h0000;
      @(negedge clk);
      ip_wr_en = 1'b0; req_valid = 1'b0;
      check("R9 old ip", int'(addr_out), phys(m_seg[0], m_ip));
      m_ip = 32'h0040;
      request("R9 new ip", 0, 1, 2, 32'h7777);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule